// File: doc/BRIEF.md
# APB3 to AXI4 Narrow Register Bridge

This block lets a 32-bit APB3 requester reach 64-bit wide registers that sit behind a 64-bit AXI4 completer. Each APB access turns into exactly one AXI4 beat of four bytes. Address bit 2 chooses which half of the 64-bit data bus carries the word. A 64-bit register is therefore written or read as two APB accesses, one at the register's 8-byte aligned address (low word) and one at that address plus four (high word).

The bridge handles one access at a time. When the APB access phase begins, it issues the AXI request and holds the APB side with PREADY low. PREADY goes high in the same cycle that the AXI write or read response is seen. A response of OKAY or EXOKAY completes the transfer cleanly. A slave or decode error raises PSLVERR.

Top module: `apb_axi_narrow_bridge`

## Requirements
- R1: Every AXI request is a single beat. AWLEN and ARLEN are 0, AWBURST and ARBURST are 2'b01, AWSIZE and ARSIZE are 3'b010, WLAST is 1, and AWID and ARID are 0.
- R2: AWADDR and ARADDR carry the APB address of the access unchanged.
- R3: On a write whose address has bit 2 = 0, WSTRB is 8'h0F and WDATA[31:0] equals PWDATA. With bit 2 = 1, WSTRB is 8'hF0 and WDATA[63:32] equals PWDATA.
- R4: On a read, in the completion cycle, PRDATA equals RDATA[63:32] when address bit 2 = 1 and RDATA[31:0] when it is 0.
- R5: A write raises AWVALID and WVALID together, in the cycle after PSEL and PENABLE are first sampled high. Each VALID then stays high, with its payload stable, until its own READY is sampled. The two handshakes may complete in any order.
- R6: A read raises ARVALID, holds it with ARADDR stable until ARREADY, and then waits for RVALID. PREADY stays low in the cycle in which ARREADY is accepted.
- R7: During an APB access phase, PREADY is high exactly in the cycles in which the pending BVALID or RVALID is high. PREADY is never high for two cycles in a row.
- R8: PSLVERR is 1 in the completion cycle when the response code (BRESP for writes, RRESP for reads) is 2'b10 or 2'b11. It is 0 for 2'b00 and 2'b01.
- R9: PSEL high with PENABLE low starts no AXI request and leaves PREADY low.
- R10: While reset is held, AWVALID, WVALID, ARVALID and PREADY are 0. A request that is in flight is abandoned.
- R11: BREADY and RREADY are held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | APB_DW | APB write word |
| prdata | output | APB_DW | APB read word |
| pready | output | 1 | APB transfer complete |
| pslverr | output | 1 | APB error |
| awid | output | ID_W | Write request ID (0) |
| awaddr | output | ADDR_W | Write address |
| awlen | output | 8 | Beats minus one (0) |
| awsize | output | 3 | Beat size code |
| awburst | output | 2 | Burst type (INCR) |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | AXI_DW | Write data |
| wstrb | output | AXI_DW/8 | Write byte strobes |
| wlast | output | 1 | Last beat (1) |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| arid | output | ID_W | Read request ID (0) |
| araddr | output | ADDR_W | Read address |
| arlen | output | 8 | Beats minus one (0) |
| arsize | output | 3 | Beat size code |
| arburst | output | 2 | Burst type (INCR) |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | AXI_DW | Read data |
| rresp | input | 2 | Read response code |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |

## Verification
Some rules are checked on every cycle by the assertions. These are the VALID hold rules with stable address, data and strobes, the count of active strobe bytes, the rule that read and write requests never overlap, the one-cycle PREADY pulse, and the rule that a read is never finished in the cycle its ARREADY is accepted. Other behaviour can only be shown by the bench's scenarios, run against a completer model with varied ready and response delays. That covers which half of the bus is steered for each value of address bit 2, which half of RDATA reaches PRDATA, the mapping of each of the four response codes onto PSLVERR, writes whose address and data handshakes finish in either order, and abandoning a request when reset arrives mid-flight.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_AWW     = 3'd1,
      ST_WAIT_W  = 3'd2,
      ST_WAIT_AW = 3'd3,
      ST_B       = 3'd4,
      ST_AR      = 3'd5,
      ST_R       = 3'd6
   } br_state_e;

   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_EXOKAY = 2'b01;
   localparam logic [1:0] RESP_SLVERR = 2'b10;
   localparam logic [1:0] RESP_DECERR = 2'b11;

   localparam logic [1:0] BURST_INCR  = 2'b01;

   function automatic logic resp_is_err(input logic [1:0] code);
      return (code == RESP_SLVERR) || (code == RESP_DECERR);
   endfunction

endpackage

// File: rtl/bridge_lanes.sv
module bridge_lanes #(
   parameter int APB_DW    = 32,
   parameter int AXI_DW    = 64,
   parameter bit REPLICATE = 1'b1,
   localparam int LANES     = AXI_DW / APB_DW,
   localparam int APB_BYTES = APB_DW / 8,
   localparam int AXI_BYTES = AXI_DW / 8,
   localparam int IDX_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [IDX_W-1:0]     word_sel,
   input  logic [APB_DW-1:0]    apb_wdata,
   input  logic [AXI_DW-1:0]    axi_rdata,
   output logic [AXI_DW-1:0]    axi_wdata,
   output logic [AXI_BYTES-1:0] axi_wstrb,
   output logic [APB_DW-1:0]    apb_rdata
);

   if ((APB_DW % 8) != 0 || APB_DW < 8) begin : g_bad_apb_w
      $error("bridge_lanes: APB_DW must be a whole number of bytes");
   end
   if (AXI_DW < APB_DW || (AXI_DW % APB_DW) != 0) begin : g_bad_ratio
      $error("bridge_lanes: AXI_DW must be a multiple of APB_DW");
   end
   if ((LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("bridge_lanes: lane count must be a power of two");
   end

   for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
      logic hit;
      assign hit = (word_sel == IDX_W'(gi));
      assign axi_wstrb[gi*APB_BYTES +: APB_BYTES] = hit ? {APB_BYTES{1'b1}} : {APB_BYTES{1'b0}};
      if (REPLICATE) begin : g_copy
         assign axi_wdata[gi*APB_DW +: APB_DW] = apb_wdata;
      end else begin : g_zero
         assign axi_wdata[gi*APB_DW +: APB_DW] = hit ? apb_wdata : {APB_DW{1'b0}};
      end
   end

   always_comb begin
      apb_rdata = '0;
      for (int i = 0; i < LANES; i++) begin
         if (word_sel == IDX_W'(i)) begin
            apb_rdata = axi_rdata[i*APB_DW +: APB_DW];
         end
      end
   end

endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
   import bridge_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_wr,
   input  logic awready,
   input  logic wready,
   input  logic bvalid,
   input  logic arready,
   input  logic rvalid,
   output logic load,
   output logic awvalid,
   output logic wvalid,
   output logic arvalid,
   output logic done,
   output logic rd_phase
);

   br_state_e st, nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;
      end else begin
         st <= nxt;
      end
   end

   always_comb begin
      nxt = st;
      unique case (st)
         ST_IDLE: begin
            if (start) nxt = start_wr ? ST_AWW : ST_AR;
         end
         ST_AWW: begin
            if (awready && wready) nxt = ST_B;
            else if (awready)      nxt = ST_WAIT_W;
            else if (wready)       nxt = ST_WAIT_AW;
         end
         ST_WAIT_W:  if (wready)  nxt = ST_B;
         ST_WAIT_AW: if (awready) nxt = ST_B;
         ST_B:       if (bvalid)  nxt = ST_IDLE;
         ST_AR:      if (arready) nxt = ST_R;
         ST_R:       if (rvalid)  nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   assign load     = (st == ST_IDLE) && start;
   assign awvalid  = (st == ST_AWW) || (st == ST_WAIT_AW);
   assign wvalid   = (st == ST_AWW) || (st == ST_WAIT_W);
   assign arvalid  = (st == ST_AR);
   assign rd_phase = (st == ST_R);
   assign done     = ((st == ST_B) && bvalid) || ((st == ST_R) && rvalid);

   // R5: each VALID holds until its READY
   a_r5_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid && !awready |=> awvalid);
   a_r5_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid && !wready |=> wvalid);
   // R5: a write opens with both channels valid at once
   a_r5_pair_open: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(awvalid) |-> wvalid);
   // R6: address held, and no completion in the ARREADY cycle
   a_r6_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid && !arready |=> arvalid);
   a_r6_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid && arready |-> !done);
   // R9: requests only follow an access phase
   a_r9_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(awvalid) || $rose(arvalid)) |-> $past(start));

endmodule

// File: rtl/apb_axi_narrow_bridge.sv
module apb_axi_narrow_bridge
   import bridge_pkg::*;
#(
   parameter int ADDR_W          = 32,
   parameter int APB_DW          = 32,
   parameter int AXI_DW          = 64,
   parameter int ID_W            = 4,
   parameter bit REPLICATE_WDATA = 1'b1,
   localparam int AXI_BYTES = AXI_DW / 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 psel,
   input  logic                 penable,
   input  logic                 pwrite,
   input  logic [ADDR_W-1:0]    paddr,
   input  logic [APB_DW-1:0]    pwdata,
   output logic [APB_DW-1:0]    prdata,
   output logic                 pready,
   output logic                 pslverr,
   output logic [ID_W-1:0]      awid,
   output logic [ADDR_W-1:0]    awaddr,
   output logic [7:0]           awlen,
   output logic [2:0]           awsize,
   output logic [1:0]           awburst,
   output logic                 awvalid,
   input  logic                 awready,
   output logic [AXI_DW-1:0]    wdata,
   output logic [AXI_BYTES-1:0] wstrb,
   output logic                 wlast,
   output logic                 wvalid,
   input  logic                 wready,
   input  logic [1:0]           bresp,
   input  logic                 bvalid,
   output logic                 bready,
   output logic [ID_W-1:0]      arid,
   output logic [ADDR_W-1:0]    araddr,
   output logic [7:0]           arlen,
   output logic [2:0]           arsize,
   output logic [1:0]           arburst,
   output logic                 arvalid,
   input  logic                 arready,
   input  logic [AXI_DW-1:0]    rdata,
   input  logic [1:0]           rresp,
   input  logic                 rvalid,
   output logic                 rready
);

   localparam int APB_BYTES = APB_DW / 8;
   localparam int LANES     = AXI_DW / APB_DW;
   localparam int SIZE_CODE = $clog2(APB_BYTES);
   localparam int SEL_LSB   = SIZE_CODE;
   localparam int IDX_W     = (LANES > 1) ? $clog2(LANES) : 1;

   if (ID_W < 1) begin : g_bad_id
      $error("apb_axi_narrow_bridge: ID_W must be at least 1");
   end
   if (ADDR_W < SEL_LSB + IDX_W) begin : g_bad_addr
      $error("apb_axi_narrow_bridge: ADDR_W too narrow for lane select");
   end

   logic              load, done, rd_phase;
   logic [ADDR_W-1:0] req_addr;
   logic [APB_DW-1:0] req_wdata;
   logic [IDX_W-1:0]  word_sel;
   logic [APB_DW-1:0] lane_rdata;

   bridge_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (psel && penable),
      .start_wr (pwrite),
      .awready  (awready),
      .wready   (wready),
      .bvalid   (bvalid),
      .arready  (arready),
      .rvalid   (rvalid),
      .load     (load),
      .awvalid  (awvalid),
      .wvalid   (wvalid),
      .arvalid  (arvalid),
      .done     (done),
      .rd_phase (rd_phase)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_addr  <= '0;
         req_wdata <= '0;
      end else if (load) begin
         req_addr  <= paddr;
         req_wdata <= pwdata;
      end
   end

   if (LANES > 1) begin : g_multi_lane
      assign word_sel = req_addr[SEL_LSB +: IDX_W];
   end else begin : g_single_lane
      assign word_sel = '0;
   end

   bridge_lanes #(
      .APB_DW    (APB_DW),
      .AXI_DW    (AXI_DW),
      .REPLICATE (REPLICATE_WDATA)
   ) u_lanes (
      .word_sel  (word_sel),
      .apb_wdata (req_wdata),
      .axi_rdata (rdata),
      .axi_wdata (wdata),
      .axi_wstrb (wstrb),
      .apb_rdata (lane_rdata)
   );

   assign awid    = '0;
   assign awaddr  = req_addr;
   assign awlen   = 8'd0;
   assign awsize  = 3'(SIZE_CODE);
   assign awburst = BURST_INCR;
   assign wlast   = 1'b1;
   assign bready  = 1'b1;

   assign arid    = '0;
   assign araddr  = req_addr;
   assign arlen   = 8'd0;
   assign arsize  = 3'(SIZE_CODE);
   assign arburst = BURST_INCR;
   assign rready  = 1'b1;

   assign pready  = done;
   assign prdata  = (done && rd_phase) ? lane_rdata : '0;
   assign pslverr = done && (rd_phase ? resp_is_err(rresp) : resp_is_err(bresp));

   // R5: payload stable while stalled
   a_r5_aw_payload: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid && !awready |=> $stable(awaddr));
   a_r5_w_payload: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid && !wready |=> $stable(wdata) && $stable(wstrb));
   // R6: read address stable while stalled
   a_r6_ar_payload: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid && !arready |=> $stable(araddr));
   // R3: exactly one word's worth of strobes on a write beat
   a_r3_strobe_count: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid |-> $countones(wstrb) == APB_BYTES);
   // R1: read and write requests never overlap
   a_r1_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
      !(arvalid && (awvalid || wvalid)));
   // R7: completion is a single-cycle pulse
   a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pready |=> !pready);

endmodule

// File: tb/apb_axi_narrow_bridge_tb.sv
module apb_axi_narrow_bridge_tb;

   typedef struct {
      bit          wr;
      logic [31:0] addr;
      logic [31:0] data;
      logic [31:0] rd_exp;
      bit          err;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        psel = 0, penable = 0, pwrite = 0;
   logic [31:0] paddr = '0, pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic [3:0]  awid, arid;
   logic [31:0] awaddr, araddr;
   logic [7:0]  awlen, arlen;
   logic [2:0]  awsize, arsize;
   logic [1:0]  awburst, arburst;
   logic        awvalid, wvalid, arvalid, wlast, bready, rready;
   logic        awready = 0, wready = 0, arready = 0, bvalid = 0, rvalid = 0;
   logic [63:0] wdata;
   logic [7:0]  wstrb;
   logic [1:0]  bresp = 0, rresp = 0;
   logic [63:0] rdata = '0;

   apb_axi_narrow_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .awid(awid), .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
      .awvalid(awvalid), .awready(awready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
      .wvalid(wvalid), .wready(wready), .bresp(bresp), .bvalid(bvalid), .bready(bready),
      .arid(arid), .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
      .arvalid(arvalid), .arready(arready), .rdata(rdata), .rresp(rresp), .rvalid(rvalid),
      .rready(rready)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   item_t exp_q[$];

   int cfg_aw_dly = 0, cfg_w_dly = 0, cfg_ar_dly = 0, cfg_rsp_dly = 0;
   logic [1:0]  cfg_resp = 2'b00;
   logic [63:0] cfg_rdata = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // completer model and monitor: drive at the falling edge, sample 1 ns later
   initial begin : slave_mon
      int aw_cnt = 0, w_cnt = 0, ar_cnt = 0, rsp_cnt = 0;
      bit aw_got = 0, w_got = 0, b_pend = 0, r_pend = 0;
      bit prev_aw_stall = 0, prev_aw = 0;
      logic [31:0] prev_awaddr = '0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            awready = 0; wready = 0; arready = 0; bvalid = 0; rvalid = 0;
            aw_cnt = 0; w_cnt = 0; ar_cnt = 0; rsp_cnt = 0;
            aw_got = 0; w_got = 0; b_pend = 0; r_pend = 0;
            prev_aw_stall = 0; prev_aw = 0;
         end else begin
            awready = awvalid && !aw_got && (aw_cnt >= cfg_aw_dly);
            if (awvalid && !aw_got) aw_cnt++;
            wready = wvalid && !w_got && (w_cnt >= cfg_w_dly);
            if (wvalid && !w_got) w_cnt++;
            arready = arvalid && (ar_cnt >= cfg_ar_dly);
            if (arvalid) ar_cnt++;
            bvalid = b_pend && (rsp_cnt >= cfg_rsp_dly);
            rvalid = r_pend && (rsp_cnt >= cfg_rsp_dly);
            if (b_pend || r_pend) rsp_cnt++;
            bresp = bvalid ? cfg_resp : 2'b00;
            rresp = rvalid ? cfg_resp : 2'b00;
            rdata = rvalid ? cfg_rdata : 64'hDEAD_DEAD_DEAD_DEAD;
         end
         #1;
         if (rst_n) begin
            bit hs;
            hs = 0;
            // R5: both channels open together, and address holds while stalled
            if (awvalid && !prev_aw)
               chk(wvalid == 1'b1, "R5", "wvalid with first awvalid", wvalid, 1);
            if (prev_aw_stall)
               chk(awvalid && awaddr == prev_awaddr, "R5", "awaddr hold", awaddr, prev_awaddr);
            prev_aw = awvalid;
            prev_aw_stall = awvalid && !awready;
            prev_awaddr = awaddr;
            if (awvalid && awready && exp_q.size() > 0) begin
               chk(awaddr == exp_q[0].addr, "R2", "awaddr", awaddr, exp_q[0].addr);
               chk(awlen == 0 && awsize == 3'b010 && awburst == 2'b01 && awid == 0,
                   "R1", "aw attributes", {awid, awlen, awsize, awburst}, 17'b01001);
               aw_got = 1; hs = 1;
            end
            if (wvalid && wready && exp_q.size() > 0) begin
               logic [7:0]  s_exp;
               logic [31:0] half;
               s_exp = exp_q[0].addr[2] ? 8'hF0 : 8'h0F;
               half  = exp_q[0].addr[2] ? wdata[63:32] : wdata[31:0];
               chk(wstrb == s_exp, "R3", "wstrb", wstrb, s_exp);
               chk(half == exp_q[0].data, "R3", "wdata half", half, exp_q[0].data);
               chk(wlast == 1'b1, "R1", "wlast", wlast, 1);
               w_got = 1; hs = 1;
            end
            if (hs && aw_got && w_got && !b_pend) begin
               b_pend = 1; rsp_cnt = 0;
            end
            if (arvalid && arready && exp_q.size() > 0) begin
               chk(araddr == exp_q[0].addr, "R2", "araddr", araddr, exp_q[0].addr);
               chk(arlen == 0 && arsize == 3'b010 && arburst == 2'b01 && arid == 0,
                   "R1", "ar attributes", {arid, arlen, arsize, arburst}, 17'b01001);
               chk(pready == 1'b0, "R6", "pready in ARREADY cycle", pready, 0);
               r_pend = 1; rsp_cnt = 0; ar_cnt = 0;
            end
            if (psel && penable)
               chk(pready == (bvalid || rvalid), "R7", "pready vs response", pready, bvalid || rvalid);
            if (psel && penable && pready) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R7", "completion with nothing pending", 1, 0);
               end else begin
                  item_t it;
                  it = exp_q.pop_front();
                  if (!it.wr)
                     chk(prdata == it.rd_exp, "R4", "prdata", prdata, it.rd_exp);
                  chk(pslverr == it.err, "R8", "pslverr", pslverr, it.err);
                  chk(bready && rready, "R11", "bready/rready", {bready, rready}, 2'b11);
               end
            end
            if (bvalid && bready) begin
               b_pend = 0; aw_got = 0; w_got = 0; aw_cnt = 0; w_cnt = 0;
            end
            if (rvalid && rready) r_pend = 0;
         end
      end
   end

   task automatic apb_do(input bit wr, input logic [31:0] a, input logic [31:0] d,
                         input logic [1:0] rsp, input logic [63:0] rd64,
                         input int awd, input int wd, input int ard, input int rspd);
      item_t it;
      int guard;
      @(negedge clk);
      cfg_aw_dly = awd; cfg_w_dly = wd; cfg_ar_dly = ard; cfg_rsp_dly = rspd;
      cfg_resp = rsp; cfg_rdata = rd64;
      it.wr = wr; it.addr = a; it.data = d;
      it.rd_exp = a[2] ? rd64[63:32] : rd64[31:0];
      it.err = rsp[1];
      exp_q.push_back(it);
      psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1;
      guard = 0;
      forever begin
         #2;
         if (pready) break;
         guard++;
         if (guard > 200) break;
         @(negedge clk);
      end
      @(negedge clk);
      psel = 0; penable = 0;
      chk(exp_q.size() == 0, "R7", "transfer completed", exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      chk(1'b0, "R7", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin : main
      // R10: outputs quiet under reset
      repeat (3) @(negedge clk);
      #2;
      chk(!awvalid && !wvalid && !arvalid && !pready, "R10", "reset outputs",
          {awvalid, wvalid, arvalid, pready}, 0);
      chk(bready && rready, "R11", "ready held in reset", {bready, rready}, 2'b11);
      @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R3 / R2: low and high word writes
      apb_do(1, 32'h0000_19F0, 32'h1122_3344, 2'b00, '0, 0, 0, 0, 0);
      apb_do(1, 32'h0000_19F4, 32'h5566_7788, 2'b00, '0, 3, 0, 0, 0);
      // R5: data accepted before address, then address before data
      apb_do(1, 32'h0000_0A08, 32'hCAFE_0001, 2'b00, '0, 4, 1, 0, 2);
      apb_do(1, 32'h0000_0A0C, 32'hCAFE_0002, 2'b00, '0, 0, 3, 0, 1);
      // R8: error responses and EXOKAY on writes
      apb_do(1, 32'h0000_1000, 32'hBAD0_0001, 2'b10, '0, 2, 2, 0, 3);
      apb_do(1, 32'h0000_1004, 32'hBAD0_0002, 2'b11, '0, 0, 0, 0, 0);
      apb_do(1, 32'h0000_1008, 32'h0000_0003, 2'b01, '0, 1, 0, 0, 0);
      // R4 / R6: reads of each half, immediate and delayed ARREADY
      apb_do(0, 32'h0000_2000, '0, 2'b00, 64'hAAAA_BBBB_CCCC_DDDD, 0, 0, 0, 0);
      apb_do(0, 32'h0000_2004, '0, 2'b00, 64'h1234_5678_9ABC_DEF0, 0, 0, 2, 3);
      apb_do(0, 32'h0000_2010, '0, 2'b10, 64'h0F0F_0F0F_F0F0_F0F0, 0, 0, 1, 1);
      apb_do(0, 32'h0000_2014, '0, 2'b01, 64'h7777_6666_5555_4444, 0, 0, 0, 2);
      apb_do(0, 32'h0000_2018, '0, 2'b11, 64'h0102_0304_0506_0708, 0, 0, 0, 0);

      // R9: setup phase alone starts nothing
      @(negedge clk);
      psel = 1; penable = 0; pwrite = 1; paddr = 32'h0000_3000; pwdata = 32'h1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         #2;
         chk(!awvalid && !wvalid && !arvalid && !pready, "R9", "setup only",
             {awvalid, wvalid, arvalid, pready}, 0);
      end
      psel = 0;

      // R10: reset abandons a stalled write
      @(negedge clk);
      cfg_aw_dly = 100; cfg_w_dly = 100;
      psel = 1; penable = 0; pwrite = 1; paddr = 32'h0000_3008; pwdata = 32'h2;
      @(negedge clk);
      penable = 1;
      repeat (3) @(negedge clk);
      #2;
      chk(awvalid && wvalid, "R5", "valids held while stalled", {awvalid, wvalid}, 2'b11);
      rst_n = 0;
      #2;
      chk(!awvalid && !wvalid && !pready, "R10", "reset mid write",
          {awvalid, wvalid, pready}, 0);
      @(negedge clk);
      psel = 0; penable = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      #2;
      chk(!awvalid && !wvalid && !arvalid, "R10", "idle after reset",
          {awvalid, wvalid, arvalid}, 0);

      // traffic resumes normally after reset
      apb_do(1, 32'h0000_19F4, 32'hFEED_BEEF, 2'b00, '0, 0, 0, 0, 1);
      apb_do(0, 32'h0000_19F0, '0, 2'b00, 64'h0BAD_F00D_600D_CAFE, 0, 0, 0, 0);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule